// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches three external interrupt pins and turns their activity into interrupt requests for a processor core. Each pin gets a two-bit sense code that picks one of four trigger modes: a held low level, any edge, a falling edge only, or a rising edge only. In the edge modes a detected edge latches a pending flag. In level mode no flag is kept, and the request follows the pin for as long as it stays low. The pin is sampled whatever its direction, so software can drive its own pin as an output to raise an interrupt.

Software reaches three registers over a simple single-cycle bus: the sense codes, a per-line enable mask, and the pending flags. A flag is cleared by writing a one to its bit, or when the core acknowledges that line as it vectors to the handler. A line reaches the core only when its mask bit and the global interrupt-enable input are both set. The combined request carries the number of the lowest-numbered active line.

Sense codes are guarded by software masking alone. Changing the code of an enabled line takes effect on the next cycle, and the request glitches that this can cause are left visible.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense, mask and flag registers read zero, and irq_o and irq_id_o are zero.
- R2: Register addresses: 0 holds the sense codes (line n in bits 2n+1:2n, bits 7:6 read zero); 1 holds the mask (line n in bit n); 2 holds the flags (line n in bit n). Bits 7:3 of the mask and flag registers read zero. Address 3 reads zero.
- R3: The sense codes for edge modes are 01 any edge, 10 falling edge and 11 rising edge. A pin change that matches the mode sets the flag, and the flag reads one after the third rising clock edge that follows the change. A change that does not match leaves the flag at zero.
- R4: Sense code 00 selects level mode. The flag stays zero, and the line is pending from the second clock edge after the pin goes low until the second clock edge after it goes high.
- R5: irq_o is one exactly when gie_i is one and some line has both its mask bit set and a pending request (a set flag, or a low pin in level mode).
- R6: irq_id_o gives the lowest-numbered line that is both masked in and pending, and 0 when there is none.
- R7: Writing a one to a flag bit at address 2 clears that flag. Writing a zero leaves it unchanged.
- R8: ack_i with ack_id_i = n clears the flag of line n only.
- R9: If an edge event and a clear (a write or an acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R10: A line whose mask bit is zero still latches its flag. Setting the mask later raises irq_o on the cycle after the write.
- R11: A write to the sense codes takes effect on the next cycle with no further guard. An enabled line whose pin is held low raises irq_o right after it is switched into level mode, and drops it right after it is switched out of level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable from the core |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational from the address |
| ack_i | input | 1 | Core acknowledges a vectored line |
| ack_id_i | input | 2 | Number of the acknowledged line |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | 2 | Lowest-numbered active line |

## Verification
On every cycle the assertions check four things: a level-mode line never holds a flag, an edge event always leaves its flag set even when a clear lands in the same cycle, write-one and acknowledge clears work, and the request is gated by the global enable and names a masked-in line. The bench scenarios cover what needs known pin history: the synchroniser delay of the edge and level paths, the match between each sense code and each pin transition, and the choice of the lowest line. They also cover the level-mode switching glitch and the late enabling of a flag latched while masked.

// File: rtl/eis_pkg.sv
`timescale 1ns/1ps
package eis_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int unsigned REG_SENSE = 0;
   localparam int unsigned REG_MASK  = 1;
   localparam int unsigned REG_FLAG  = 2;
endpackage

// File: rtl/eis_sync.sv
`timescale 1ns/1ps
module eis_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eis_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/eis_line.sv
`timescale 1ns/1ps
module eis_line
   import eis_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] sense_i,
   input  logic       clr_i,
   output logic       flag_o,
   output logic       evt_o,
   output logic       pend_o
);
   logic s_cur, s_prev, level, flag_q;

   eis_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_i),
      .dout (s_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b1;
      else        s_prev <= s_cur;
   end

   assign level = (sense_e'(sense_i) == SENSE_LOW);

   always_comb begin
      unique case (sense_e'(sense_i))
         SENSE_ANY:  evt_o = s_cur ^ s_prev;
         SENSE_FALL: evt_o = s_prev & ~s_cur;
         SENSE_RISE: evt_o = ~s_prev & s_cur;
         default:    evt_o = 1'b0;
      endcase
   end

   // hardware set has priority over any clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (level) flag_q <= 1'b0;
      else if (evt_o) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign pend_o = level ? ~s_cur : flag_q;
endmodule

// File: rtl/eis_prio.sv
`timescale 1ns/1ps
module eis_prio #(
   parameter int N    = 3,
   parameter int ID_W = 2
) (
   input  logic [N-1:0]    act_i,
   output logic            any_o,
   output logic [ID_W-1:0] id_o
);
   always_comb begin
      id_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (act_i[i]) id_o = ID_W'(i);
      end
   end

   assign any_o = |act_i;
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense
   import eis_pkg::*;
#(
   parameter int NUM_LINES   = 3,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int ID_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int SENSE_W    = 2 * NUM_LINES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic              gie_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              ack_i,
   input  logic [ID_W-1:0]   ack_id_i,
   output logic              irq_o,
   output logic [ID_W-1:0]   irq_id_o
);
   if (NUM_LINES < 1 || SENSE_W > DATA_W) begin : g_bad_lines
      $error("ext_irq_sense: sense codes must fit in one data word");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ext_irq_sense: ADDR_W must hold three register addresses");
   end

   logic [SENSE_W-1:0]   sense_q;
   logic [NUM_LINES-1:0] mask_q, flag_q, evt_w, pend_w, clr_w;
   logic wr_sense, wr_mask, wr_flag, any_act;

   assign wr_sense = bus_wr_i && (bus_addr_i == ADDR_W'(REG_SENSE));
   assign wr_mask  = bus_wr_i && (bus_addr_i == ADDR_W'(REG_MASK));
   assign wr_flag  = bus_wr_i && (bus_addr_i == ADDR_W'(REG_FLAG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         mask_q  <= '0;
      end else begin
         if (wr_sense) sense_q <= bus_wdata_i[SENSE_W-1:0];
         if (wr_mask)  mask_q  <= bus_wdata_i[NUM_LINES-1:0];
      end
   end

   if (DATA_W > SENSE_W) begin : g_unused_data
      logic unused_wdata;
      assign unused_wdata = ^bus_wdata_i[DATA_W-1:SENSE_W];
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      assign clr_w[n] = (wr_flag && bus_wdata_i[n]) ||
                        (ack_i && (ack_id_i == ID_W'(n)));
      eis_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[n]),
         .sense_i(sense_q[2*n +: 2]),
         .clr_i  (clr_w[n]),
         .flag_o (flag_q[n]),
         .evt_o  (evt_w[n]),
         .pend_o (pend_w[n])
      );
   end

   eis_prio #(.N(NUM_LINES), .ID_W(ID_W)) u_prio (
      .act_i(pend_w & mask_q),
      .any_o(any_act),
      .id_o (irq_id_o)
   );

   assign irq_o = gie_i && any_act;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(REG_SENSE))     bus_rdata_o[SENSE_W-1:0]   = sense_q;
      else if (bus_addr_i == ADDR_W'(REG_MASK)) bus_rdata_o[NUM_LINES-1:0] = mask_q;
      else if (bus_addr_i == ADDR_W'(REG_FLAG)) bus_rdata_o[NUM_LINES-1:0] = flag_q;
   end
endmodule

// File: rtl/eis_checker.sv
`timescale 1ns/1ps
module eis_checker #(
   parameter int NUM_LINES = 3,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int ID_W      = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   gie_i,
   input logic                   irq_o,
   input logic [ID_W-1:0]        irq_id_o,
   input logic                   ack_i,
   input logic [ID_W-1:0]        ack_id_i,
   input logic                   bus_wr_i,
   input logic [ADDR_W-1:0]      bus_addr_i,
   input logic [DATA_W-1:0]      bus_wdata_i,
   input logic [2*NUM_LINES-1:0] sense_q,
   input logic [NUM_LINES-1:0]   mask_q,
   input logic [NUM_LINES-1:0]   flag_q,
   input logic [NUM_LINES-1:0]   evt_w
);
   logic flag_wr;
   assign flag_wr = bus_wr_i && (bus_addr_i == ADDR_W'(2));

   a_r5_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !irq_o);

   a_r6_id_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> mask_q[irq_id_o]);

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
      a_r4_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (sense_q[2*n +: 2] == 2'b00) |=> !flag_q[n]);

      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         evt_w[n] |=> flag_q[n]);

      a_r7_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && bus_wdata_i[n] && !evt_w[n]) |=> !flag_q[n]);

      a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && !bus_wdata_i[n] && flag_q[n] && !bus_wdata_i[n]
          && !(ack_i && ack_id_i == ID_W'(n))
          && sense_q[2*n +: 2] != 2'b00) |=> flag_q[n]);

      a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i && ack_id_i == ID_W'(n) && !evt_w[n]) |=> !flag_q[n]);
   end
endmodule

bind ext_irq_sense eis_checker #(
   .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_eis_checker (
   .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .irq_o(irq_o), .irq_id_o(irq_id_o),
   .ack_i(ack_i), .ack_id_i(ack_id_i), .bus_wr_i(bus_wr_i),
   .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
   .sense_q(sense_q), .mask_q(mask_q), .flag_q(flag_q), .evt_w(evt_w)
);

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] pin = 3'b111;
   logic       gie = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ack = 1'b0;
   logic [1:0] ack_id = '0;
   logic       irq;
   logic [1:0] irq_id;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ext_irq_sense i_ext_irq_sense (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .gie_i(gie),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .ack_i(ack), .ack_id_i(ack_id),
      .irq_o(irq), .irq_id_o(irq_id)
   );

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input int addr, input int data);
      bus_addr  = 2'(addr);
      bus_wdata = 8'(data);
      bus_wr    = 1'b1;
      step(1);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int addr, output int val);
      bus_addr = 2'(addr);
      #1;
      val = int'(bus_rdata);
   endtask

   function automatic int lowest(input int v);
      for (int k = 0; k < 3; k++) if (v[k]) return k;
      return 0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      int v;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      rd(0, v); chk("R1 sense", v, 0);
      rd(1, v); chk("R1 mask", v, 0);
      rd(2, v); chk("R1 flag", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 irq_id", int'(irq_id), 0);

      // R2 register layout
      wr(1, 8'hFF); rd(1, v); chk("R2 mask width", v, 8'h07);
      wr(0, 8'hFF); rd(0, v); chk("R2 sense width", v, 8'h3F);
      rd(3, v); chk("R2 unused address", v, 0);
      wr(0, 0); wr(1, 0);

      // R3 edge modes: every line, mode and transition direction
      gie = 1'b1;
      for (int ln = 0; ln < 3; ln++) begin
         for (int md = 1; md < 4; md++) begin
            for (int rise = 0; rise < 2; rise++) begin
               int exp;
               exp = (md == 1) || (md == 2 && rise == 0) || (md == 3 && rise == 1);
               wr(0, md << (2 * ln));
               wr(1, 1 << ln);
               pin[ln] = (rise == 0);
               step(4);
               wr(2, 7);
               pin[ln] = (rise == 1);
               step(2);
               rd(2, v); chk("R3 flag not yet set", (v >> ln) & 1, 0);
               step(1);
               rd(2, v); chk("R3 flag after third edge", (v >> ln) & 1, exp);
               chk("R5 irq from edge flag", int'(irq), exp);
               chk("R6 id of edge line", int'(irq_id), exp ? ln : 0);
               if (exp) begin
                  ack = 1'b1; ack_id = 2'(ln);
                  step(1);
                  ack = 1'b0;
                  rd(2, v); chk("R8 ack clears flag", (v >> ln) & 1, 0);
               end
               pin[ln] = 1'b1;
               step(4);
               wr(2, 7);
            end
         end
      end

      // R4 level mode timing and no flag
      wr(0, 0); wr(1, 7);
      pin = 3'b111; step(3);
      pin[1] = 1'b0;
      step(1); chk("R4 level not yet", int'(irq), 0);
      step(1); chk("R4 level request", int'(irq), 1);
      chk("R6 id line 1", int'(irq_id), 1);
      rd(2, v); chk("R4 level flag stays zero", v, 0);
      pin[1] = 1'b1;
      step(1); chk("R4 level held", int'(irq), 1);
      step(1); chk("R4 level release", int'(irq), 0);

      // R5 R6 sweep over pins, mask and global enable in level mode
      for (int g = 0; g < 2; g++) begin
         for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
               int act;
               gie = g[0];
               pin = 3'(p);
               wr(1, m);
               step(1);
               act = (~p) & m & 7;
               chk("R5 combined request", int'(irq), (g == 1 && act != 0) ? 1 : 0);
               chk("R6 lowest line", int'(irq_id), lowest(act));
            end
         end
      end
      pin = 3'b111; gie = 1'b1; step(3);

      // R7 write-one-to-clear, R8 selective ack
      wr(1, 0); wr(0, 6'b010101);
      pin = 3'b000; step(3); pin = 3'b111; step(4);
      rd(2, v); chk("R3 any-edge flags", v, 7);
      wr(2, 0); rd(2, v); chk("R7 zero write keeps", v, 7);
      wr(2, 5); rd(2, v); chk("R7 one clears", v, 2);
      pin = 3'b000; step(4);
      rd(2, v); chk("R3 any-edge falling", v, 7);
      ack = 1'b1; ack_id = 2'd2; step(1); ack = 1'b0;
      rd(2, v); chk("R8 ack line 2 only", v, 3);
      wr(2, 7); rd(2, v); chk("R7 clear all", v, 0);

      // R9 set beats clear in the same cycle
      pin = 3'b111; step(4);
      rd(2, v); chk("R9 setup flag", v & 1, 1);
      pin[0] = 1'b0;
      step(2);
      bus_addr = 2'd2; bus_wdata = 8'h01; bus_wr = 1'b1;
      ack = 1'b1; ack_id = 2'd0;
      step(1);
      bus_wr = 1'b0; ack = 1'b0;
      rd(2, v); chk("R9 set wins over clear", v & 1, 1);
      wr(2, 7); rd(2, v); chk("R9 later clear works", v, 0);

      // R10 masked line latches flag, enabling raises irq
      pin = 3'b111; wr(0, 6'b110000); wr(1, 0); step(3);
      pin[2] = 1'b0; step(3); pin[2] = 1'b1; step(3);
      rd(2, v); chk("R10 masked flag latched", v, 4);
      chk("R10 no irq while masked", int'(irq), 0);
      wr(1, 4);
      chk("R10 irq after mask write", int'(irq), 1);
      chk("R10 id", int'(irq_id), 2);
      wr(2, 7);

      // R11 sense change glitch on enabled line with pin low
      wr(0, 6'b110000); wr(1, 4);
      pin[2] = 1'b0; step(4); wr(2, 7);
      chk("R11 no irq before switch", int'(irq), 0);
      wr(0, 6'b000000);
      chk("R11 irq right after switch to level", int'(irq), 1);
      chk("R11 id", int'(irq_id), 2);
      wr(0, 6'b110000);
      chk("R11 irq drops after leaving level", int'(irq), 0);
      rd(2, v); chk("R11 no flag from mode change", v, 0);

      summary();
      $finish;
   end
endmodule